// File: doc/BRIEF.md
# Latched BCD Seven-Segment Digit Decoder with Ripple Blanking

This block drives one digit of a seven-segment display from a synchronous design. A 4-bit BCD value is captured into a hold register on a rising clock edge while the load enable is high. The stored value is then decoded into seven segment bits. Codes above nine light nothing.

Three live controls act on the decoded pattern without any clock delay. A blank input turns off every segment. A ripple-blank input blanks the digit when the stored value is zero. A ripple-blank output reports that case so that it can feed the next digit. The last stage is a phase input that inverts all seven bits. Phase 0 suits common-cathode LEDs and phase 1 suits common-anode LEDs. For a liquid-crystal panel, the same square wave goes to the phase input and to the backplane.

To suppress leading zeros, the most significant digit's ripple input is tied high and each ripple output feeds the next lower digit. For trailing zeros the chain starts at the least significant digit and runs upward.

Top module: `bcd_seg_digit`

## Requirements
- R1: On a rising clock edge with `load_en` high and `rst` low, the hold register takes `code_in`. With `load_en` low it keeps its value, and changes on `code_in` do not reach the outputs.
- R2: A synchronous active-high `rst` clears the hold register to 0000 at the clock edge, so afterwards the digit shows zero (`seg` = 7'h3F with phase 0, blank 0, ripple-in 0).
- R3: `seg` bit order is {g,f,e,d,c,b,a}. With phase 0 and no blanking, stored values 0..9 give 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex). Segment a is lit for 6 and segment d is lit for 9.
- R4: Stored values 10 to 15 give an all-off pattern before the phase stage.
- R5: While `blank` is 1, all seven segments are off before the phase stage, whatever the stored value and `rbi`.
- R6: With `rbi` = 1, a stored zero is blanked and any nonzero stored value is shown normally. With `rbi` = 0, a stored zero is shown as the digit 0.
- R7: `rbo` is 1 exactly when `rbi` is 1 and the stored value is 0000, independent of `blank` and `phase`.
- R8: `phase` = 1 inverts all seven bits of the pattern as the final stage, including blanked and illegal-code patterns, which then read 7'h7F.
- R9: `seg` and `rbo` follow changes on `blank`, `rbi` and `phase` in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the hold register |
| load_en | input | 1 | 1: hold register loads `code_in` each edge; 0: hold |
| code_in | input | 4 | BCD value to capture |
| blank | input | 1 | Forces all segments off before the phase stage |
| rbi | input | 1 | Ripple-blank input: blank this digit if it holds zero |
| phase | input | 1 | Inverts every segment bit as the last stage |
| seg | output | 7 | Segment drive, bits {g,f,e,d,c,b,a} |
| rbo | output | 1 | Ripple-blank output to the next digit in the chain |

## Verification
Some properties are checked on every cycle: the hold and load behaviour of the stored value, reset to zero, off patterns for illegal values and forced blanking, the implication from the ripple output to a zero value with the ripple input set, and full inversion when only the phase toggles. The segment shapes of the ten digits, and the way the ripple signal travels through a row of digits, can only be shown by the bench. It chains four instances for leading-zero suppression and four for trailing-zero suppression, and it compares every digit with a model under directed and random codes.

// File: rtl/bcd_seg_digit.sv
module bcd_seg_digit (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_en,
  input  logic [3:0] code_in,
  input  logic       blank,
  input  logic       rbi,
  input  logic       phase,
  output logic [6:0] seg,
  output logic       rbo
);

  logic [3:0] held;
  logic [6:0] shape;

  always_ff @(posedge clk) begin
    if (rst)          held <= 4'd0;
    else if (load_en) held <= code_in;
  end

  // bit order {g,f,e,d,c,b,a}
  always_comb begin
    case (held)
      4'd0:    shape = 7'b0111111;
      4'd1:    shape = 7'b0000110;
      4'd2:    shape = 7'b1011011;
      4'd3:    shape = 7'b1001111;
      4'd4:    shape = 7'b1100110;
      4'd5:    shape = 7'b1101101;
      4'd6:    shape = 7'b1111101;
      4'd7:    shape = 7'b0000111;
      4'd8:    shape = 7'b1111111;
      4'd9:    shape = 7'b1101111;
      default: shape = 7'b0000000;
    endcase
  end

  assign rbo = rbi & (held == 4'd0);
  assign seg = ((blank | rbo) ? 7'b0000000 : shape) ^ {7{phase}};

endmodule

// File: rtl/bcd_seg_digit_chk.sv
module bcd_seg_digit_chk (
  input logic       clk,
  input logic       rst,
  input logic       load_en,
  input logic [3:0] code_in,
  input logic       blank,
  input logic       rbi,
  input logic       phase,
  input logic [3:0] held,
  input logic [6:0] seg,
  input logic       rbo
);

  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(held));

  a_r1_load: assert property (@(posedge clk) disable iff (rst)
    load_en |=> held == $past(code_in));

  a_r2_reset: assert property (@(posedge clk)
    rst |=> held == 4'd0);

  a_r4_illegal: assert property (@(posedge clk) disable iff (rst)
    (held > 4'd9) |-> seg == {7{phase}});

  a_r5_blank: assert property (@(posedge clk) disable iff (rst)
    blank |-> seg == {7{phase}});

  a_r6_ripple_off: assert property (@(posedge clk) disable iff (rst)
    rbo |-> seg == {7{phase}});

  a_r7_rbo_cause: assert property (@(posedge clk) disable iff (rst)
    rbo |-> (rbi && held == 4'd0));

  a_r8_phase_flip: assert property (@(posedge clk) disable iff (rst)
    ($stable(held) && $stable(blank) && $stable(rbi) && phase != $past(phase))
      |-> seg == ~$past(seg));

endmodule

bind bcd_seg_digit bcd_seg_digit_chk u_chk (
  .clk(clk), .rst(rst), .load_en(load_en), .code_in(code_in),
  .blank(blank), .rbi(rbi), .phase(phase), .held(held),
  .seg(seg), .rbo(rbo)
);

// File: tb/bcd_seg_digit_test.sv
`timescale 1ns/1ps
module bcd_seg_digit_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_en = 1'b0;
  logic [3:0] code = 4'd0;
  logic       blank = 1'b0;
  logic       rbi = 1'b0;
  logic       phase = 1'b0;
  logic [6:0] seg;
  logic       rbo;

  logic [3:0] lc [4];
  logic [3:0] tc [4];
  logic [6:0] lseg [4];
  logic [6:0] tseg [4];
  logic [4:0] lrb;
  logic [4:0] trb;

  logic [3:0] mh;
  logic [3:0] lh [4];
  logic [3:0] th [4];

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bcd_seg_digit uut (
    .clk(clk), .rst(rst), .load_en(load_en), .code_in(code),
    .blank(blank), .rbi(rbi), .phase(phase), .seg(seg), .rbo(rbo));

  assign lrb[4] = 1'b1;
  assign trb[0] = 1'b1;

  for (genvar i = 0; i < 4; i++) begin : g_chain
    bcd_seg_digit u_lead (
      .clk(clk), .rst(rst), .load_en(load_en), .code_in(lc[i]),
      .blank(blank), .rbi(lrb[i+1]), .phase(phase), .seg(lseg[i]), .rbo(lrb[i]));
    bcd_seg_digit u_trail (
      .clk(clk), .rst(rst), .load_en(load_en), .code_in(tc[i]),
      .blank(blank), .rbi(trb[i]), .phase(phase), .seg(tseg[i]), .rbo(trb[i+1]));
  end

  function automatic logic [6:0] exp_seg(input logic [3:0] c, input logic b,
                                         input logic r, input logic p);
    logic [6:0] s;
    case (c)
      4'd0: s = 7'h3F;  4'd1: s = 7'h06;  4'd2: s = 7'h5B;  4'd3: s = 7'h4F;
      4'd4: s = 7'h66;  4'd5: s = 7'h6D;  4'd6: s = 7'h7D;  4'd7: s = 7'h07;
      4'd8: s = 7'h7F;  4'd9: s = 7'h6F;  default: s = 7'h00;
    endcase
    if (b || (r && c == 4'd0)) s = 7'h00;
    return s ^ {7{p}};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual {rbo,seg}=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic r;
    check(tag, {rbo, seg}, {rbi && mh == 4'd0, exp_seg(mh, blank, rbi, phase)});
    r = 1'b1;
    for (int i = 3; i >= 0; i--) begin
      check({tag, " / R6 R7 leading chain"}, {lrb[i], lseg[i]},
            {r && lh[i] == 4'd0, exp_seg(lh[i], blank, r, phase)});
      r = r && lh[i] == 4'd0;
    end
    r = 1'b1;
    for (int i = 0; i < 4; i++) begin
      check({tag, " / R6 R7 trailing chain"}, {trb[i+1], tseg[i]},
            {r && th[i] == 4'd0, exp_seg(th[i], blank, r, phase)});
      r = r && th[i] == 4'd0;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst) begin
      mh = 4'd0;
      for (int i = 0; i < 4; i++) begin lh[i] = 4'd0; th[i] = 4'd0; end
    end else if (load_en) begin
      mh = code;
      for (int i = 0; i < 4; i++) begin lh[i] = lc[i]; th[i] = tc[i]; end
    end
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) begin lc[i] = 4'd0; tc[i] = 4'd0; end
    mh = 4'hx;
    repeat (2) tick();
    tick();
    @(negedge clk);
    rst = 1'b0;
    #1 check_all("R2 reset shows zero");
    rbi = 1'b1;
    #1 check_all("R2 R7 reset value with ripple-in");
    rbi = 1'b0;

    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      load_en = 1'b1; code = 4'(c); phase = 1'b0;
      tick();
      check_all(c < 10 ? "R3 digit decode" : "R4 illegal code off");
      @(negedge clk);
      load_en = 1'b0; phase = 1'b1;
      #1 check_all("R8 R9 phase inverts");
      phase = 1'b0;
    end

    @(negedge clk);
    load_en = 1'b1; code = 4'd7;
    tick();
    @(negedge clk);
    load_en = 1'b0; code = 4'd2;
    tick();
    check_all("R1 hold with load low");
    check({"R1 held seven"}, {rbo, seg}, {1'b0, 7'h07});

    @(negedge clk);
    load_en = 1'b1; code = 4'd8;
    tick();
    @(negedge clk);
    blank = 1'b1;
    #1 check_all("R5 R9 blank forces off");
    phase = 1'b1;
    #1 check_all("R5 R8 blank with phase");
    blank = 1'b0; phase = 1'b0; rbi = 1'b1;
    #1 check_all("R6 nonzero shown with ripple-in");

    @(negedge clk);
    code = 4'd0;
    tick();
    blank = 1'b1;
    #1 check_all("R7 rbo independent of blank");
    blank = 1'b0; rbi = 1'b0;
    #1 check_all("R6 zero shown without ripple-in");

    @(negedge clk);
    lc[3] = 4'd0; lc[2] = 4'd0; lc[1] = 4'd5; lc[0] = 4'd0;
    tc[3] = 4'd1; tc[2] = 4'd0; tc[1] = 4'd0; tc[0] = 4'd0;
    tick();
    check_all("R6 directed leading/trailing");
    check("R6 leading d2 blank", {lrb[2], lseg[2]}, {1'b1, 7'h00});
    check("R6 leading d0 zero shown", {lrb[0], lseg[0]}, {1'b0, 7'h3F});
    check("R6 trailing d3 shows 1", {trb[4], tseg[3]}, {1'b0, 7'h06});
    for (int i = 0; i < 4; i++) begin lc[i] = 4'd0; tc[i] = 4'd0; end
    @(negedge clk);
    tick();
    check_all("R6 all-zero row blanked");

    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      load_en = ($urandom % 3) != 0;
      code = 4'($urandom % 12);
      blank = ($urandom % 8) == 0;
      rbi = $urandom % 2;
      phase = $urandom % 2;
      for (int i = 0; i < 4; i++) begin
        lc[i] = ($urandom % 2) ? 4'd0 : 4'($urandom % 10);
        tc[i] = ($urandom % 2) ? 4'd0 : 4'($urandom % 10);
      end
      tick();
      check_all("R1 R3 R5 R6 R8 random");
    end

    @(negedge clk);
    rst = 1'b1;
    tick();
    @(negedge clk);
    rst = 1'b0; load_en = 1'b0; blank = 1'b0; rbi = 1'b0; phase = 1'b0;
    #1 check_all("R2 reset after traffic");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule